// File: doc/BRIEF.md
# H-Bridge Channel Drive Controller

This block is the digital control core for a set of H-bridge motor channels. Each channel reads two logic inputs and turns them into four registered drive requests. These are a high-side and a low-side enable for each half-bridge output, so each output can be pulled up, pulled down or left floating. Every bridge on the chip shares two global controls. One decides whether a channel that is told to coast first recirculates its current for a timed interval (about 1 ms) or floats at once. The other switches the last channels into constant-current chopping. In that mode a synchronised current-over-reference flag removes the active drive for a minimum off-time.

When every channel input is low, a standby indication is raised and the block floats all outputs. An undervoltage flag or an overtemperature flag also floats every output. The block sits between the command logic and the gate drivers. Dead-time shaping, sensing and the power stage are handled elsewhere.

Top module: `hbc_top`

## Requirements
- R1: During and straight after synchronous reset, every enable and the standby flag are low, and no recirculation starts before a channel has first left code 00.
- R2: Channel code {A,B} is decoded as follows: 10 gives forward (A high-side on, B low-side on), 01 gives reverse (B high-side on, A low-side on), 11 gives brake (both low-sides on) and 00 gives open. Each output is registered one clock after its inputs are sampled, so a new code can be followed on every cycle.
- R3: An output never has its high-side and low-side enables on in the same cycle.
- R4: When all 2*NCH channel inputs are low, standby is high on the next cycle and all enables are off. Any recirculation in progress is cancelled.
- R5: With the recirculate select low, code 00 floats both outputs on the next cycle. Lowering the select during recirculation floats the outputs on the next cycle and ends the interval.
- R6: With the recirculate select high, entering code 00 from any other code turns on both low-sides for exactly REGEN_CYCLES cycles, and then both outputs float. Holding 00 does not restart the interval.
- R7: A non-00 code that arrives during recirculation cancels it at once: the new code is driven on the next cycle. A later entry to 00 starts a full new interval.
- R8: With the chopping mode input low, the chopping-capable channels (the top NCHOP channels; comparator bit j belongs to channel NCH-NCHOP+j) behave like all other channels, and their comparator has no effect.
- R9: With the chopping mode input high, a comparator flag passes through two synchroniser flops. Each cycle in which the synchronised flag is high, and the CHOP_OFF_CYCLES cycles after it falls, forward and reverse drive are replaced by all-off. Brake and open are unaffected.
- R10: An undervoltage or overtemperature input floats every output on the next cycle and cancels any recirculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | NCH | First control input of each channel |
| in_b | input | NCH | Second control input of each channel |
| regen_sel | input | 1 | High: coast recirculates before floating |
| chop_mode | input | 1 | High: top NCHOP channels chop on comparator |
| cmp_over | input | NCHOP | Asynchronous current-over-reference flags |
| uv_fault | input | 1 | Supply undervoltage |
| ot_fault | input | 1 | Overtemperature |
| hi_a | output | NCH | High-side enable, output A |
| lo_a | output | NCH | Low-side enable, output A |
| hi_b | output | NCH | High-side enable, output B |
| lo_b | output | NCH | Low-side enable, output B |
| standby | output | 1 | All channel inputs low |

## Verification
The bench sweeps every code-to-code transition on every channel with recirculation both off and on. This catches a decoder with swapped directions, or a timer that runs one cycle short or long or restarts while 00 is held. It cancels recirculation mid-interval with each non-zero code and with a drop of the select. A channel that kept recirculating would show its low-sides one cycle too long. Comparator pulses of one and several cycles are driven on both chopping channels, in and out of chopping mode and under brake and open codes. Errors in the synchroniser latency, the off-time length or the code gating therefore show up on an exact cycle. Standby, faults and long random traffic are checked against a cycle model. A standby or fault path that let recirculation survive would leave low-sides on where all-off is expected.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [1:0] {
    CODE_OPEN  = 2'b00,
    CODE_REV   = 2'b01,
    CODE_FWD   = 2'b10,
    CODE_BRAKE = 2'b11
  } code_t;

  typedef struct packed {
    logic hi_a;
    logic lo_a;
    logic hi_b;
    logic lo_b;
  } bridge_drv_t;

  localparam bridge_drv_t DRV_OFF   = '{hi_a: 1'b0, lo_a: 1'b0, hi_b: 1'b0, lo_b: 1'b0};
  localparam bridge_drv_t DRV_FWD   = '{hi_a: 1'b1, lo_a: 1'b0, hi_b: 1'b0, lo_b: 1'b1};
  localparam bridge_drv_t DRV_REV   = '{hi_a: 1'b0, lo_a: 1'b1, hi_b: 1'b1, lo_b: 1'b0};
  localparam bridge_drv_t DRV_LOWS  = '{hi_a: 1'b0, lo_a: 1'b1, hi_b: 1'b0, lo_b: 1'b1};

endpackage

// File: rtl/hbc_sync2.sv
module hbc_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hbc_chop.sv
module hbc_chop #(
  parameter int unsigned OFF_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic cmp_raw,
  output logic chop_off
);
  localparam int unsigned OW = $clog2(OFF_CYCLES + 1);

  logic          cmp_s;
  logic [OW-1:0] off_q;

  hbc_sync2 #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cmp_raw),
    .q   (cmp_s)
  );

  always_ff @(posedge clk) begin
    if (rst)              off_q <= '0;
    else if (!en)         off_q <= '0;
    else if (cmp_s)       off_q <= OW'(OFF_CYCLES);
    else if (off_q != '0) off_q <= off_q - 1'b1;
  end

  assign chop_off = en && (cmp_s || (off_q != '0));

  // R9
  flag_holds_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_s && en) |=> (!en || chop_off));
endmodule

// File: rtl/hbc_chan.sv
module hbc_chan
  import hbc_pkg::*;
#(
  parameter int unsigned REGEN_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic a,
  input  logic b,
  input  logic regen_sel,
  input  logic chop_off,
  input  logic kill,
  output logic hi_a,
  output logic lo_a,
  output logic hi_b,
  output logic lo_b
);
  localparam int unsigned RW = $clog2(REGEN_CYCLES + 1);

  code_t         code;
  code_t         prev_q;
  logic [RW-1:0] rcnt_q, rcnt_d;
  bridge_drv_t   drv_q, drv_d;
  logic          regen_start;

  assign code        = code_t'({a, b});
  assign regen_start = (code == CODE_OPEN) && (prev_q != CODE_OPEN) && regen_sel;

  always_comb begin
    drv_d  = DRV_OFF;
    rcnt_d = rcnt_q;
    if (kill) begin
      rcnt_d = '0;
    end else begin
      case (code)
        CODE_FWD: begin
          rcnt_d = '0;
          if (!chop_off) drv_d = DRV_FWD;
        end
        CODE_REV: begin
          rcnt_d = '0;
          if (!chop_off) drv_d = DRV_REV;
        end
        CODE_BRAKE: begin
          rcnt_d = '0;
          drv_d  = DRV_LOWS;
        end
        default: begin
          if (regen_start) begin
            rcnt_d = RW'(REGEN_CYCLES - 1);
            drv_d  = DRV_LOWS;
          end else if (regen_sel && (rcnt_q != '0)) begin
            rcnt_d = rcnt_q - 1'b1;
            drv_d  = DRV_LOWS;
          end else begin
            rcnt_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= CODE_OPEN;
      rcnt_q <= '0;
      drv_q  <= DRV_OFF;
    end else begin
      prev_q <= code;
      rcnt_q <= rcnt_d;
      drv_q  <= drv_d;
    end
  end

  assign hi_a = drv_q.hi_a;
  assign lo_a = drv_q.lo_a;
  assign hi_b = drv_q.hi_b;
  assign lo_b = drv_q.lo_b;

  // R3
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_a && lo_a) && !(hi_b && lo_b));

  // R2
  fwd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_FWD && !kill && !chop_off) |=> (hi_a && lo_b && !lo_a && !hi_b));

  // R5
  open_float_chk: assert property (@(posedge clk) disable iff (rst)
    (code == CODE_OPEN && !regen_sel) |=> !(hi_a || lo_a || hi_b || lo_b));

  // R6
  regen_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (regen_start && !kill) |=> (lo_a && lo_b && !hi_a && !hi_b));
endmodule

// File: rtl/hbc_top.sv
module hbc_top #(
  parameter int unsigned NCH             = 6,
  parameter int unsigned NCHOP           = 2,
  parameter int unsigned CLK_HZ          = 50_000_000,
  parameter int unsigned REGEN_CYCLES    = CLK_HZ / 1000,
  parameter int unsigned CHOP_OFF_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   in_a,
  input  logic [NCH-1:0]   in_b,
  input  logic             regen_sel,
  input  logic             chop_mode,
  input  logic [NCHOP-1:0] cmp_over,
  input  logic             uv_fault,
  input  logic             ot_fault,
  output logic [NCH-1:0]   hi_a,
  output logic [NCH-1:0]   lo_a,
  output logic [NCH-1:0]   hi_b,
  output logic [NCH-1:0]   lo_b,
  output logic             standby
);
  localparam int unsigned PLAIN = NCH - NCHOP;

  logic           all_idle;
  logic           kill;
  logic [NCH-1:0] chop_off_w;
  logic           standby_q;

  assign all_idle = (in_a == '0) && (in_b == '0);
  assign kill     = all_idle || uv_fault || ot_fault;

  always_ff @(posedge clk) begin
    if (rst) standby_q <= 1'b0;
    else     standby_q <= all_idle;
  end
  assign standby = standby_q;

  for (genvar p = 0; p < PLAIN; p++) begin : g_plain
    assign chop_off_w[p] = 1'b0;
  end

  for (genvar j = 0; j < NCHOP; j++) begin : g_chop
    hbc_chop #(.OFF_CYCLES(CHOP_OFF_CYCLES)) u_chop (
      .clk      (clk),
      .rst      (rst),
      .en       (chop_mode),
      .cmp_raw  (cmp_over[j]),
      .chop_off (chop_off_w[PLAIN + j])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hbc_chan #(.REGEN_CYCLES(REGEN_CYCLES)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .a         (in_a[c]),
      .b         (in_b[c]),
      .regen_sel (regen_sel),
      .chop_off  (chop_off_w[c]),
      .kill      (kill),
      .hi_a      (hi_a[c]),
      .lo_a      (lo_a[c]),
      .hi_b      (hi_b[c]),
      .lo_b      (lo_b[c])
    );
  end

  // R10
  fault_float_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_fault || ot_fault) |=> ((hi_a | lo_a | hi_b | lo_b) == '0));

  // R4
  standby_float_chk: assert property (@(posedge clk) disable iff (rst)
    standby |-> ((hi_a | lo_a | hi_b | lo_b) == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!standby && ((hi_a | lo_a | hi_b | lo_b) == '0)));
endmodule

// File: tb/sim_hbc_top.sv
module sim_hbc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 6;
  localparam int NCHOP = 2;
  localparam int RGN   = 6;
  localparam int OFFC  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   ia = '0, ib = '0;
  logic             sel = 1'b0, mode = 1'b0, uv = 1'b0, ot = 1'b0;
  logic [NCHOP-1:0] cmp = '0;
  logic [NCH-1:0]   ha, la, hb, lb;
  logic             sb;

  int    checks = 0, failures = 0;
  bit    chk_en = 1'b0, done = 1'b0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  hbc_top #(.NCH(NCH), .NCHOP(NCHOP), .CLK_HZ(RGN*1000), .REGEN_CYCLES(RGN),
            .CHOP_OFF_CYCLES(OFFC)) u0 (
    .clk(clk), .rst(rst), .in_a(ia), .in_b(ib), .regen_sel(sel), .chop_mode(mode),
    .cmp_over(cmp), .uv_fault(uv), .ot_fault(ot),
    .hi_a(ha), .lo_a(la), .hi_b(hb), .lo_b(lb), .standby(sb));

  // cycle model built from the requirements
  logic [1:0] m_prev [NCH];
  int         m_rc   [NCH];
  int         m_oc   [NCHOP];
  logic       m_s1   [NCHOP];
  logic       m_s2   [NCHOP];
  logic [NCH-1:0] e_ha = '0, e_la = '0, e_hb = '0, e_lb = '0;
  logic           e_sb = 1'b0;

  always @(posedge clk) begin
    logic [1:0] cd;
    logic       cut, idle, kl;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin m_prev[c] = 2'b00; m_rc[c] = 0; end
      for (int j = 0; j < NCHOP; j++) begin m_oc[j] = 0; m_s1[j] = 0; m_s2[j] = 0; end
      e_ha = '0; e_la = '0; e_hb = '0; e_lb = '0; e_sb = 1'b0;
    end else begin
      idle = (ia == '0) && (ib == '0);
      kl   = idle || uv || ot;
      for (int c = 0; c < NCH; c++) begin
        cd  = {ia[c], ib[c]};
        cut = (c >= NCH-NCHOP) && mode &&
              (m_s2[c-(NCH-NCHOP)] || m_oc[c-(NCH-NCHOP)] != 0);
        e_ha[c] = 0; e_la[c] = 0; e_hb[c] = 0; e_lb[c] = 0;
        if (kl) m_rc[c] = 0;
        else if (cd == 2'b10) begin m_rc[c] = 0; if (!cut) begin e_ha[c] = 1; e_lb[c] = 1; end end
        else if (cd == 2'b01) begin m_rc[c] = 0; if (!cut) begin e_hb[c] = 1; e_la[c] = 1; end end
        else if (cd == 2'b11) begin m_rc[c] = 0; e_la[c] = 1; e_lb[c] = 1; end
        else if (sel && m_prev[c] != 2'b00) begin m_rc[c] = RGN-1; e_la[c] = 1; e_lb[c] = 1; end
        else if (sel && m_rc[c] != 0) begin m_rc[c]--; e_la[c] = 1; e_lb[c] = 1; end
        else m_rc[c] = 0;
        m_prev[c] = cd;
      end
      for (int j = 0; j < NCHOP; j++) begin
        if (!mode) m_oc[j] = 0;
        else if (m_s2[j]) m_oc[j] = OFFC;
        else if (m_oc[j] != 0) m_oc[j]--;
        m_s2[j] = m_s1[j];
        m_s1[j] = cmp[j];
      end
      e_sb = idle;
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      checks++;
      if ({ha, la, hb, lb, sb} !== {e_ha, e_la, e_hb, e_lb, e_sb}) begin
        failures++;
        $display("FAIL %s t=%0t act ha=%b la=%b hb=%b lb=%b sb=%b exp ha=%b la=%b hb=%b lb=%b sb=%b",
                 phase, $time, ha, la, hb, lb, sb, e_ha, e_la, e_hb, e_lb, e_sb);
      end
      checks++;
      if (((ha & la) | (hb & lb)) !== '0) begin
        failures++;
        $display("FAIL R3 overlap act=%b exp=%b", (ha & la) | (hb & lb), {NCH{1'b0}});
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int ch, input logic [1:0] cd);
    ia[ch] = cd[1];
    ib[ch] = cd[0];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      done = 1'b1;
      $finish;
    end
  end

  initial begin
    step(1);
    chk_en = 1'b1;
    step(3);                              // R1 reset state
    rst = 1'b0;
    phase = "R1 after reset";
    step(3);

    // R2 / R5: every code transition on every channel, recirculation off
    phase = "R2 R5 decode sweep";
    sel = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      ia = '0; ib = '0;
      put((ch == 0) ? 1 : 0, 2'b10);
      for (int c1 = 0; c1 < 4; c1++)
        for (int c2 = 0; c2 < 4; c2++) begin
          put(ch, c1[1:0]); step(1);
          put(ch, c2[1:0]); step(1);
        end
    end

    // R6 / R7: recirculation length, restart and cancellation
    phase = "R6 R7 recirculation";
    sel = 1'b1;
    for (int ch = 0; ch < NCH; ch++) begin
      ia = '0; ib = '0;
      put((ch == 0) ? 1 : 0, 2'b01);
      for (int c1 = 1; c1 < 4; c1++) begin
        put(ch, c1[1:0]); step(2);
        put(ch, 2'b00);   step(RGN + 3);
        put(ch, c1[1:0]); step(1);
        put(ch, 2'b00);   step(2);
        put(ch, 2'((c1 % 3) + 1)); step(1);
        put(ch, 2'b00);   step(RGN + 2);
      end
      // R5: select dropped mid-interval
      phase = "R5 select drop";
      put(ch, 2'b11); step(1);
      put(ch, 2'b00); step(2);
      sel = 1'b0;     step(2);
      sel = 1'b1;     step(RGN + 1);
      phase = "R6 R7 recirculation";
    end

    // R4: standby cancels recirculation
    phase = "R4 standby";
    ia = 6'b101010; ib = 6'b010101; step(2);
    ia = '0; ib = '0; step(4);
    ia[2] = 1'b1; step(1);
    ia = '0; step(RGN + 2);

    // R10: faults
    phase = "R10 faults";
    ia = 6'b110011; ib = 6'b011110;
    uv = 1'b1; step(2); uv = 1'b0; step(1);
    ib[0] = 1'b0; ia[0] = 1'b0; ot = 1'b1; step(2); ot = 1'b0; step(RGN + 2);
    for (int i = 0; i < 60; i++) begin
      ia = NCH'($urandom); ib = NCH'($urandom);
      uv = ($urandom % 4) == 0; ot = ($urandom % 4) == 0;
      step(1);
    end
    uv = 1'b0; ot = 1'b0;

    // R8: comparator ignored when chopping mode is low
    phase = "R8 chop disabled";
    sel = 1'b0; mode = 1'b0;
    ia = 6'b010011; ib = 6'b100011;
    cmp = 2'b11; step(6); cmp = 2'b00; step(3);

    // R9: chopping pulses of several widths, under each code
    phase = "R9 chopping";
    mode = 1'b1;
    for (int w = 1; w < 6; w++) begin
      cmp = 2'b01; step(w); cmp = 2'b00; step(OFFC + 4);
      cmp = 2'b10; step(w); cmp = 2'b00; step(OFFC + 4);
      cmp = 2'b11; step(w); cmp = 2'b00; step(1);
      cmp = 2'b01; step(1); cmp = 2'b00; step(OFFC + 4);
    end
    put(4, 2'b11); put(5, 2'b00);
    cmp = 2'b11; step(5); cmp = 2'b00; step(OFFC + 3);
    put(4, 2'b10); put(5, 2'b01);
    cmp = 2'b11; step(3); mode = 1'b0; step(2); mode = 1'b1; step(OFFC + 3);

    // all requirements under random traffic
    phase = "R2 R3 R6 R9 random";
    for (int i = 0; i < 4000; i++) begin
      ia   = NCH'($urandom); ib = NCH'($urandom);
      if (($urandom % 3) == 0) ia = '0;
      if (($urandom % 3) == 0) ib = '0;
      if (($urandom % 8) == 0) begin ia = '0; ib = '0; ia[$urandom % NCH] = 1'b1; end
      sel  = ($urandom % 8) != 0;
      mode = ($urandom % 6) != 0;
      cmp  = NCHOP'($urandom);
      uv   = ($urandom % 50) == 0;
      ot   = ($urandom % 50) == 0;
      step(1 + ($urandom % (RGN + 2)) * (($urandom % 4) == 0 ? 1 : 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule